// File: doc/BRIEF.md
# Coherence Invariant Checking Monitor

This block is a passive observer that sits beside a cache hierarchy and checks, cycle by cycle, that the permission and data traffic of several cores obeys the two coherence invariants. The first is the single-writer/multiple-reader rule: at any moment a block has one core with read-write permission or any number of read-only holders, never both. The second is the data-value rule: a block's value at the start of every epoch equals the value it had when its most recent read-write epoch closed, so every reader in a read-only epoch sees that same value. The monitor implements no protocol. It only mirrors the permissions that the real protocol reports and raises sticky flags when that protocol misbehaves.

Each core presents at most one event per cycle. The event carries an opcode, a block address and, for loads and stores, the data. Checking is at block granularity. A store counts against the whole block, so two cores storing to different bytes of one block collide like any other pair of writers. Block state lives in a small fully associative table. Entries are allocated on first touch and are never freed. The monitor reports the epoch kind of every table entry, three sticky violation flags, a sticky overflow flag and a record of the first violation. A synchronous clear input empties all of these.

Top module: `coh_mon`

## Requirements
- R1: After reset, all error flags, `overflow` and `first_valid` are 0, `slot_used` is all zero and `epoch_rw` is all zero. Every slot holds `init_value` as its block value and has no permission holders.
- R2: The per-core opcode field is encoded as follows: 0 idle, 1 grant read-only, 2 grant read-write, 3 revoke, 4 load, 5 store. Codes 6 and 7 behave as idle. A non-idle event to an address missing from the table takes the lowest-numbered free slot and sets its `slot_used` bit. Slots are never released.
- R3: A non-idle event to a new address when all slots are used sets the sticky `overflow` flag. That event is otherwise ignored.
- R4: A grant of read-write to a core while any other core holds read-only or read-write on the block sets `err_swmr` with error code 1. A sole reader that upgrades raises no error. A grant moves the core out of its previous permission.
- R5: A grant of read-only to a core while another core holds read-write on the block sets `err_swmr` with code 1.
- R6: `epoch_rw[s]` is 1 exactly when some core holds read-write on the block in slot s. A revoke removes every permission of that core on that block.
- R7: A store by a core without read-write permission sets `err_access` with code 3 and leaves the block value unchanged. A store by the read-write holder replaces the whole 32-bit block value.
- R8: A load by a core holding neither read-only nor read-write permission sets `err_access` with code 3.
- R9: A permitted load whose data differs in any bit from the block value sets `err_value` with code 2. The block value is `init_value`, or the last store made by a read-write holder.
- R10: Events in one cycle take effect in ascending core order, each seeing the changes of lower-numbered cores. When several cores err in one cycle, the lowest-numbered one is recorded.
- R11: The error flags stay set, and `first_core`, `first_addr` and `first_code` hold the earliest error, until `clr_err` is high at a clock edge. That edge clears all flags, the record and `overflow`. Errors and overflow arising in that same cycle are dropped, although table updates still happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_err | input | 1 | Synchronous clear of flags and first-error record |
| init_value | input | 32 | Block value loaded into every slot at reset |
| core_op | input | 15 | Opcode per core, core c at bits [3c+2:3c] |
| core_addr | input | 80 | Block address per core, 16 bits each |
| core_data | input | 160 | Load or store data per core, 32 bits each |
| err_swmr | output | 1 | Sticky single-writer violation |
| err_value | output | 1 | Sticky data-value violation |
| err_access | output | 1 | Sticky access-without-permission violation |
| overflow | output | 1 | Sticky table overflow |
| first_valid | output | 1 | First-error record is valid |
| first_core | output | 3 | Core of the first error |
| first_addr | output | 16 | Block address of the first error |
| first_code | output | 2 | Code of the first error: 1 swmr, 2 value, 3 access |
| epoch_rw | output | 8 | Per slot: 1 for a read-write epoch, 0 for read-only |
| slot_used | output | 8 | Per slot: entry allocated |

## Verification
The assertions assume that reset is held low for at least one clock edge before any event. They also assume that `init_value` is stable while reset is low. They do not depend on events being legal, so illegal sequences are fair stimulus. The bench therefore drives a directed script of legal and deliberately illegal grant, load and store sequences, followed by a seeded random phase. The random phase confines addresses to a set of eight blocks and data to a set of four values, so the table fills, value mismatches occur, and multi-core same-cycle collisions happen often.

// File: rtl/coh_mon_pkg.sv
// Shared encodings for the coherence invariant monitor.
package coh_mon_pkg;
    typedef logic [2:0] op_t;
    typedef logic [1:0] err_t;

    localparam op_t OP_IDLE     = 3'd0;
    localparam op_t OP_GRANT_RO = 3'd1;
    localparam op_t OP_GRANT_RW = 3'd2;
    localparam op_t OP_REVOKE   = 3'd3;
    localparam op_t OP_LOAD     = 3'd4;
    localparam op_t OP_STORE    = 3'd5;

    localparam err_t ERR_NONE   = 2'd0;
    localparam err_t ERR_SWMR   = 2'd1;
    localparam err_t ERR_VALUE  = 2'd2;
    localparam err_t ERR_ACCESS = 2'd3;
endpackage

// File: rtl/coh_mon_unpack.sv
// Splits the flattened per-core event buses into per-core fields.
// Assumes: opcodes above OP_STORE are reserved and are mapped to idle here.
module coh_mon_unpack
    import coh_mon_pkg::*;
#(
    parameter int NC = 5,
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic [NC*3-1:0]         core_op,
    input  logic [NC*AW-1:0]        core_addr,
    input  logic [NC*DW-1:0]        core_data,
    output op_t  [NC-1:0]           op,
    output logic [NC-1:0][AW-1:0]   addr,
    output logic [NC-1:0][DW-1:0]   data
);
    for (genvar c = 0; c < NC; c++) begin : g_core
        // Slice one core's fields and squash reserved opcodes to idle.
        always_comb begin
            op[c]   = (core_op[c*3 +: 3] > OP_STORE) ? OP_IDLE : core_op[c*3 +: 3];
            addr[c] = core_addr[c*AW +: AW];
            data[c] = core_data[c*DW +: DW];
        end
    end
endmodule

// File: rtl/coh_mon_table.sv
// Tracked-block table: per slot the address, reader mask, writer mask and
// block value. Applies every core's event of a cycle in ascending core order
// and reports a per-core violation code plus a table-overflow strobe.
// Assumes: at most one event per core per cycle; slots are never freed.
module coh_mon_table
    import coh_mon_pkg::*;
#(
    parameter int NC = 5,
    parameter int NB = 8,
    parameter int AW = 16,
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [DW-1:0]           init_value,
    input  op_t  [NC-1:0]           op,
    input  logic [NC-1:0][AW-1:0]   addr,
    input  logic [NC-1:0][DW-1:0]   data,
    output err_t [NC-1:0]           ev_err,
    output logic                    ovf_hit,
    output logic [NB-1:0]           epoch_rw,
    output logic [NB-1:0]           slot_used
);
    localparam int SW = (NB > 1) ? $clog2(NB) : 1;

    logic [NB-1:0]          v_q, n_v;
    logic [NB-1:0][AW-1:0]  a_q, n_a;
    logic [NB-1:0][NC-1:0]  rd_q, n_rd, wr_q, n_wr;
    logic [NB-1:0][DW-1:0]  val_q, n_val;
    logic                   hit, found;
    logic [SW-1:0]          idx;
    logic [NC-1:0]          self;

    // Sequentially apply each core's event to a working copy of the table.
    always_comb begin
        n_v = v_q; n_a = a_q; n_rd = rd_q; n_wr = wr_q; n_val = val_q;
        ev_err = '0; ovf_hit = 1'b0;
        hit = 1'b0; found = 1'b0; idx = '0; self = '0;
        for (int c = 0; c < NC; c++) begin
            hit = 1'b0; found = 1'b0; idx = '0;
            self = '0; self[c] = 1'b1;
            if (op[c] != OP_IDLE) begin
                for (int s = 0; s < NB; s++)
                    if (!hit && n_v[s] && n_a[s] == addr[c]) begin
                        hit = 1'b1; idx = SW'(s);
                    end
                for (int s = 0; s < NB; s++)
                    if (!hit && !found && !n_v[s]) begin
                        found = 1'b1; idx = SW'(s);
                    end
                if (!hit && !found) begin
                    ovf_hit = 1'b1;
                end else begin
                    if (!hit) begin
                        n_v[idx] = 1'b1;
                        n_a[idx] = addr[c];
                    end
                    case (op[c])
                        OP_GRANT_RO: begin
                            if ((n_wr[idx] & ~self) != '0) ev_err[c] = ERR_SWMR;
                            n_rd[idx] = n_rd[idx] | self;
                            n_wr[idx] = n_wr[idx] & ~self;
                        end
                        OP_GRANT_RW: begin
                            if (((n_rd[idx] | n_wr[idx]) & ~self) != '0) ev_err[c] = ERR_SWMR;
                            n_wr[idx] = n_wr[idx] | self;
                            n_rd[idx] = n_rd[idx] & ~self;
                        end
                        OP_REVOKE: begin
                            n_rd[idx] = n_rd[idx] & ~self;
                            n_wr[idx] = n_wr[idx] & ~self;
                        end
                        OP_LOAD: begin
                            if (((n_rd[idx] | n_wr[idx]) & self) == '0) ev_err[c] = ERR_ACCESS;
                            else if (data[c] != n_val[idx])             ev_err[c] = ERR_VALUE;
                        end
                        OP_STORE: begin
                            if ((n_wr[idx] & self) == '0) ev_err[c] = ERR_ACCESS;
                            else                          n_val[idx] = data[c];
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // Register the updated table; reset empties it and seeds every value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q <= '0; a_q <= '0; rd_q <= '0; wr_q <= '0;
            for (int s = 0; s < NB; s++) val_q[s] <= init_value;
        end else begin
            v_q <= n_v; a_q <= n_a; rd_q <= n_rd; wr_q <= n_wr; val_q <= n_val;
        end
    end

    for (genvar s = 0; s < NB; s++) begin : g_epoch
        // A slot is in a read-write epoch when any core holds write permission.
        assign epoch_rw[s] = |wr_q[s];
    end
    assign slot_used = v_q;
endmodule

// File: rtl/coh_mon_errlog.sv
// Sticky violation flags, sticky overflow and the first-error record.
// Assumes: ev_err carries at most one code per core per cycle; the lowest
// erring core wins the record; clr_err dominates any error in its cycle.
module coh_mon_errlog
    import coh_mon_pkg::*;
#(
    parameter int NC = 5,
    parameter int AW = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_err,
    input  err_t [NC-1:0]           ev_err,
    input  logic [NC-1:0][AW-1:0]   addr,
    input  logic                    ovf_hit,
    output logic                    err_swmr,
    output logic                    err_value,
    output logic                    err_access,
    output logic                    overflow,
    output logic                    first_valid,
    output logic [$clog2(NC)-1:0]   first_core,
    output logic [AW-1:0]           first_addr,
    output err_t                    first_code
);
    localparam int CW = $clog2(NC);

    logic           any_err, any_swmr, any_value, any_access;
    logic [CW-1:0]  pick_core;
    logic [AW-1:0]  pick_addr;
    err_t           pick_code;

    // Reduce this cycle's codes and choose the lowest-numbered erring core.
    always_comb begin
        any_err = 1'b0; any_swmr = 1'b0; any_value = 1'b0; any_access = 1'b0;
        pick_core = '0; pick_addr = '0; pick_code = ERR_NONE;
        for (int c = NC - 1; c >= 0; c--) begin
            if (ev_err[c] != ERR_NONE) begin
                any_err   = 1'b1;
                pick_core = CW'(c);
                pick_addr = addr[c];
                pick_code = ev_err[c];
            end
            any_swmr   = any_swmr   | (ev_err[c] == ERR_SWMR);
            any_value  = any_value  | (ev_err[c] == ERR_VALUE);
            any_access = any_access | (ev_err[c] == ERR_ACCESS);
        end
    end

    // Hold the flags and the first record until a clear or reset.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_err) begin
            err_swmr <= 1'b0; err_value <= 1'b0; err_access <= 1'b0;
            overflow <= 1'b0; first_valid <= 1'b0;
            first_core <= '0; first_addr <= '0; first_code <= ERR_NONE;
        end else begin
            err_swmr   <= err_swmr   | any_swmr;
            err_value  <= err_value  | any_value;
            err_access <= err_access | any_access;
            overflow   <= overflow   | ovf_hit;
            if (!first_valid && any_err) begin
                first_valid <= 1'b1;
                first_core  <= pick_core;
                first_addr  <= pick_addr;
                first_code  <= pick_code;
            end
        end
    end
endmodule

// File: rtl/coh_mon.sv
// Top of the coherence invariant monitor. Purely observes per-core grant,
// revoke, load and store events and flags single-writer, data-value and
// access breaches at block granularity.
// Assumes: synchronous active-low reset; one event per core per cycle.
module coh_mon
    import coh_mon_pkg::*;
#(
    parameter int NC = 5,
    parameter int NB = 8,
    parameter int AW = 16,
    parameter int DW = 32,
    localparam int CW = $clog2(NC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_err,
    input  logic [DW-1:0]      init_value,
    input  logic [NC*3-1:0]    core_op,
    input  logic [NC*AW-1:0]   core_addr,
    input  logic [NC*DW-1:0]   core_data,
    output logic               err_swmr,
    output logic               err_value,
    output logic               err_access,
    output logic               overflow,
    output logic               first_valid,
    output logic [CW-1:0]      first_core,
    output logic [AW-1:0]      first_addr,
    output logic [1:0]         first_code,
    output logic [NB-1:0]      epoch_rw,
    output logic [NB-1:0]      slot_used
);
    op_t  [NC-1:0]          op;
    logic [NC-1:0][AW-1:0]  addr;
    logic [NC-1:0][DW-1:0]  data;
    err_t [NC-1:0]          ev_err;
    logic                   ovf_hit;

    coh_mon_unpack #(.NC(NC), .AW(AW), .DW(DW)) unpack_i (
        .core_op(core_op), .core_addr(core_addr), .core_data(core_data),
        .op(op), .addr(addr), .data(data)
    );

    coh_mon_table #(.NC(NC), .NB(NB), .AW(AW), .DW(DW)) table_i (
        .clk(clk), .rst_n(rst_n), .init_value(init_value),
        .op(op), .addr(addr), .data(data),
        .ev_err(ev_err), .ovf_hit(ovf_hit),
        .epoch_rw(epoch_rw), .slot_used(slot_used)
    );

    coh_mon_errlog #(.NC(NC), .AW(AW)) errlog_i (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
        .ev_err(ev_err), .addr(addr), .ovf_hit(ovf_hit),
        .err_swmr(err_swmr), .err_value(err_value), .err_access(err_access),
        .overflow(overflow), .first_valid(first_valid),
        .first_core(first_core), .first_addr(first_addr), .first_code(first_code)
    );
endmodule

// File: rtl/coh_mon_checker.sv
// Port-level properties of the coherence monitor, bound into every instance.
module coh_mon_checker #(
    parameter int NB = 8,
    parameter int CW = 3,
    parameter int AW = 16
) (
    input logic           clk,
    input logic           rst_n,
    input logic           clr_err,
    input logic           err_swmr,
    input logic           err_value,
    input logic           err_access,
    input logic           overflow,
    input logic           first_valid,
    input logic [CW-1:0]  first_core,
    input logic [AW-1:0]  first_addr,
    input logic [1:0]     first_code,
    input logic [NB-1:0]  epoch_rw,
    input logic [NB-1:0]  slot_used
);
    // R2: allocated slots are never released
    assert_slots_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((slot_used & $past(slot_used)) == $past(slot_used)));

    // R3: overflow can only be raised once every slot is in use
    assert_overflow_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> (&slot_used));

    // R6: a read-write epoch only exists on an allocated slot
    assert_epoch_on_used_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (epoch_rw & ~slot_used) == '0);

    // R11: violation flags stay set until a clear
    assert_sticky_flags_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_err && (err_swmr || err_value || err_access)) |=>
        ((err_swmr >= $past(err_swmr)) && (err_value >= $past(err_value)) &&
         (err_access >= $past(err_access))));

    // R11: the first-error record is frozen while valid and not cleared
    assert_first_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (first_valid && !clr_err) |=>
        (first_valid && $stable(first_core) && $stable(first_addr) && $stable(first_code)));

    // R11: a clear empties every flag and the record
    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err |=> (!err_swmr && !err_value && !err_access && !overflow && !first_valid));

    // R4: a valid record always carries a nonzero code
    assert_code_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (first_code != 2'd0));
endmodule

bind coh_mon coh_mon_checker #(.NB(NB), .CW(CW), .AW(AW)) checker_i (
    .clk(clk), .rst_n(rst_n), .clr_err(clr_err),
    .err_swmr(err_swmr), .err_value(err_value), .err_access(err_access),
    .overflow(overflow), .first_valid(first_valid), .first_core(first_core),
    .first_addr(first_addr), .first_code(first_code),
    .epoch_rw(epoch_rw), .slot_used(slot_used)
);

// File: tb/coh_mon_tb_top.sv
// Bench for coh_mon: behavioural reference model compared on every clock.
module coh_mon_tb_top;
    localparam int NC = 5;
    localparam int NB = 8;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam logic [DW-1:0] INIT = 32'hA5A5_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_err = 1'b0;
    logic [DW-1:0] init_value = INIT;
    logic [NC*3-1:0] core_op = '0;
    logic [NC*AW-1:0] core_addr = '0;
    logic [NC*DW-1:0] core_data = '0;
    logic err_swmr, err_value, err_access, overflow, first_valid;
    logic [2:0] first_core;
    logic [AW-1:0] first_addr;
    logic [1:0] first_code;
    logic [NB-1:0] epoch_rw, slot_used;

    always #2 clk = ~clk;

    coh_mon dut_i (
        .clk(clk), .rst_n(rst_n), .clr_err(clr_err), .init_value(init_value),
        .core_op(core_op), .core_addr(core_addr), .core_data(core_data),
        .err_swmr(err_swmr), .err_value(err_value), .err_access(err_access),
        .overflow(overflow), .first_valid(first_valid), .first_core(first_core),
        .first_addr(first_addr), .first_code(first_code),
        .epoch_rw(epoch_rw), .slot_used(slot_used)
    );

    int n_checks = 0;
    int n_fail = 0;

    // pending stimulus
    int p_op[NC];
    int p_addr[NC];
    logic [DW-1:0] p_data[NC];
    bit p_clr;

    // reference model state
    bit m_v[NB];
    int m_a[NB];
    bit m_rd[NB][NC];
    bit m_wr[NB][NC];
    logic [DW-1:0] m_val[NB];
    bit e_swmr, e_value, e_access, e_ovf, e_fv;
    int e_core, e_addr, e_code;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int s = 0; s < NB; s++) begin
            m_v[s] = 0; m_a[s] = 0; m_val[s] = INIT;
            for (int c = 0; c < NC; c++) begin m_rd[s][c] = 0; m_wr[s][c] = 0; end
        end
        e_swmr = 0; e_value = 0; e_access = 0; e_ovf = 0; e_fv = 0;
        e_core = 0; e_addr = 0; e_code = 0;
    endtask

    // Apply pending events to the model following the requirements.
    task automatic model_step();
        int err[NC];
        bit ovf;
        ovf = 0;
        for (int c = 0; c < NC; c++) begin
            int sl;
            bit other_rd, other_wr;
            err[c] = 0;
            if (p_op[c] < 1 || p_op[c] > 5) continue;
            sl = -1;
            for (int s = 0; s < NB; s++) if (sl < 0 && m_v[s] && m_a[s] == p_addr[c]) sl = s;
            if (sl < 0) for (int s = 0; s < NB; s++) if (sl < 0 && !m_v[s]) begin
                sl = s; m_v[s] = 1; m_a[s] = p_addr[c];
            end
            if (sl < 0) begin ovf = 1; continue; end
            other_rd = 0; other_wr = 0;
            for (int k = 0; k < NC; k++) if (k != c) begin
                other_rd |= m_rd[sl][k]; other_wr |= m_wr[sl][k];
            end
            case (p_op[c])
                1: begin if (other_wr) err[c] = 1; m_rd[sl][c] = 1; m_wr[sl][c] = 0; end
                2: begin if (other_wr || other_rd) err[c] = 1; m_wr[sl][c] = 1; m_rd[sl][c] = 0; end
                3: begin m_rd[sl][c] = 0; m_wr[sl][c] = 0; end
                4: begin
                    if (!m_rd[sl][c] && !m_wr[sl][c]) err[c] = 3;
                    else if (p_data[c] !== m_val[sl]) err[c] = 2;
                end
                default: begin
                    if (!m_wr[sl][c]) err[c] = 3; else m_val[sl] = p_data[c];
                end
            endcase
        end
        if (p_clr) begin
            e_swmr = 0; e_value = 0; e_access = 0; e_ovf = 0; e_fv = 0;
            e_core = 0; e_addr = 0; e_code = 0;
        end else begin
            e_ovf |= ovf;
            for (int c = 0; c < NC; c++) begin
                if (err[c] == 1) e_swmr = 1;
                if (err[c] == 2) e_value = 1;
                if (err[c] == 3) e_access = 1;
                if (err[c] != 0 && !e_fv) begin
                    e_fv = 1; e_core = c; e_addr = p_addr[c]; e_code = err[c];
                end
            end
        end
    endtask

    task automatic compare_all();
        logic [NB-1:0] exp_rw, exp_used;
        for (int s = 0; s < NB; s++) begin
            bit w;
            w = 0;
            for (int c = 0; c < NC; c++) w |= m_wr[s][c];
            exp_rw[s] = w; exp_used[s] = m_v[s];
        end
        chk(slot_used == exp_used, "R2", "slot_used", slot_used, exp_used);
        chk(epoch_rw == exp_rw, "R6", "epoch_rw", epoch_rw, exp_rw);
        chk(err_swmr == e_swmr, "R4", "err_swmr", err_swmr, e_swmr);
        chk(err_value == e_value, "R9", "err_value", err_value, e_value);
        chk(err_access == e_access, "R7", "err_access", err_access, e_access);
        chk(overflow == e_ovf, "R3", "overflow", overflow, e_ovf);
        chk(first_valid == e_fv, "R11", "first_valid", first_valid, e_fv);
        if (e_fv) begin
            chk(first_core == 3'(e_core), "R10", "first_core", first_core, e_core);
            chk(first_addr == AW'(e_addr), "R11", "first_addr", first_addr, e_addr);
            chk(first_code == 2'(e_code), "R11", "first_code", first_code, e_code);
        end
    endtask

    task automatic ev(input int c, input int op, input int a, input logic [DW-1:0] d);
        p_op[c] = op; p_addr[c] = a; p_data[c] = d;
    endtask

    // One clock: drive at negedge, advance model, compare after the edge.
    task automatic tick();
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            core_op[c*3 +: 3] = 3'(p_op[c]);
            core_addr[c*AW +: AW] = AW'(p_addr[c]);
            core_data[c*DW +: DW] = p_data[c];
        end
        clr_err = p_clr;
        model_step();
        @(posedge clk);
        #1;
        compare_all();
        for (int c = 0; c < NC; c++) begin p_op[c] = 0; p_addr[c] = 0; p_data[c] = '0; end
        p_clr = 0;
    endtask

    task automatic clear();
        p_clr = 1; tick();
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) begin p_op[c] = 0; p_addr[c] = 0; p_data[c] = '0; end
        p_clr = 0;
        model_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk(!err_swmr && !err_value && !err_access && !overflow && !first_valid,
            "R1", "flags after reset", {err_swmr, err_value, err_access, overflow, first_valid}, 0);
        chk(slot_used == '0 && epoch_rw == '0, "R1", "table after reset",
            {slot_used, epoch_rw}, 0);

        // Shared read-only epoch on 0x10, load of the reset value is clean
        ev(0, 1, 'h10, 0); ev(1, 1, 'h10, 0); tick();
        ev(0, 4, 'h10, INIT); ev(1, 4, 'h10, INIT); tick();
        // R4: read-write grant while two readers remain
        ev(2, 2, 'h10, 0); tick();
        chk(first_code == 2'd1 && first_core == 3'd2, "R4", "swmr record",
            {first_core, first_code}, {3'd2, 2'd1});
        clear();
        ev(0, 3, 'h10, 0); ev(1, 3, 'h10, 0); tick();
        ev(2, 5, 'h10, 32'h1111); tick();
        chk(epoch_rw[0] == 1'b1, "R6", "rw epoch on slot 0", epoch_rw[0], 1);
        // R9: new read-only epoch starts with the last written value
        ev(2, 3, 'h10, 0); ev(3, 1, 'h10, 0); tick();
        ev(3, 4, 'h10, 32'h1111); tick();
        ev(4, 1, 'h10, 0); tick();
        ev(4, 4, 'h10, 32'h2222); tick();
        chk(err_value && first_code == 2'd2, "R9", "value mismatch", first_code, 2);
        clear();

        // R5: read-only grant while another core writes
        ev(1, 2, 'h20, 0); tick();
        ev(0, 1, 'h20, 0); tick();
        chk(err_swmr && first_core == 3'd0, "R5", "ro vs rw", first_core, 0);
        clear();

        // R8: load without permission; R7: store without write permission
        ev(4, 4, 'h30, INIT); tick();
        chk(err_access && first_code == 2'd3, "R8", "load no perm", first_code, 3);
        ev(4, 5, 'h30, 32'h5); tick();
        clear();
        ev(4, 1, 'h30, 0); tick();
        ev(4, 4, 'h30, INIT); tick();
        chk(!err_value, "R7", "refused store left value", err_value, 0);

        // R10: same-cycle errors, lowest core recorded
        clear();
        ev(1, 4, 'h40, 0); ev(3, 5, 'h40, 7); tick();
        chk(first_core == 3'd1, "R10", "lowest core wins", first_core, 1);
        clear();
        ev(0, 2, 'h50, 0); ev(1, 1, 'h50, 0); tick();
        chk(err_swmr && first_core == 3'd1, "R10", "ordered grants", first_core, 1);
        clear();

        // R4: sole-reader upgrade is clean
        ev(2, 1, 'h60, 0); tick();
        ev(2, 2, 'h60, 0); tick();
        chk(!err_swmr, "R4", "upgrade clean", err_swmr, 0);

        // R2/R3: fill the table, then overflow
        ev(0, 1, 'h70, 0); ev(1, 1, 'h80, 0); tick();
        chk(slot_used == 8'hFF, "R2", "table full", slot_used, 8'hFF);
        ev(2, 1, 'h90, 0); tick();
        chk(overflow, "R3", "overflow set", overflow, 1);
        // R11: clear drops an error raised in its own cycle
        p_clr = 1; ev(3, 4, 'h90, 0); ev(4, 4, 'h70, 0); tick();
        chk(!overflow && !err_access, "R11", "clear dominates", {overflow, err_access}, 0);

        // Seeded random phase on the allocated blocks
        void'($urandom(32'd77));
        for (int i = 0; i < 3000; i++) begin
            for (int c = 0; c < NC; c++) begin
                int pick;
                pick = int'($urandom % 4);
                ev(c, int'($urandom % 8), 'h10 * (1 + int'($urandom % 8)),
                   (pick == 0) ? INIT : DW'(pick));
            end
            p_clr = ($urandom % 40) == 0;
            tick();
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule